// File: doc/BRIEF.md
# DS3 Frame-Master Transmit Timing Generator

This block sets the frame timing of an outgoing DS3 bitstream from a free-running local bit clock. No outside frame reference is used: the block alone decides where each 4760-bit frame begins. It takes a serial payload stream from upstream system equipment and places it into the payload positions of the frame. It fills the 56 overhead positions from an overhead vector that it samples once per frame. The merged bitstream appears on a single serial output.

Two strobes pace the upstream source. A one-clock frame strobe marks the first slot of each frame. A one-clock overhead indicator goes high one clock before every overhead slot. The source answers the indicator by holding its next payload bit for one clock, so that no payload bit is lost in the gap. A strap selects serial operation. When the strap asks for the nibble-wide interface, which this block does not provide, the generator stays idle.

The frame is 7 subframes of 680 bits. Each subframe is 8 blocks of 85 bits, and each block is one overhead bit followed by 84 payload bits.

Top module: `ds3_tx_frame_master`

## Requirements
- R1: The frame is 4760 clocks long, and slot 0 is the first overhead bit. `frame_strobe` is high for exactly the one clock in which slot 0 is processed, so consecutive strobes are 4760 clocks apart.
- R2: `oh_ind` is high for exactly one clock, in the last payload slot of every 85-bit block, which is the clock before each overhead slot. That gives 56 pulses per frame.
- R3: In a payload slot the block samples `pay_in`, and that bit appears on `ser_out` one clock later. In an overhead slot `pay_in` is not sampled. Payload order is kept across every overhead gap, and each frame carries exactly 4704 payload bits.
- R4: The overhead slot of block b (0..7) in subframe s (0..6) outputs bit 8*s+b of `oh_vec_in`, one clock after the slot. The vector is sampled in the frame-start clock, and that same clock already uses the new value for bit 0. Changes to `oh_vec_in` during the rest of the frame have no effect.
- R5: `frame_ref_in` has no effect on any output.
- R6: While `nib_sel` is high, the frame position is held at slot 0, both strobes are low, and `ser_out` is 0 one clock later. The first clock after `nib_sel` falls is a frame start with `frame_strobe` high.
- R7: Synchronous active-high `rst` returns the frame position to slot 0 and keeps both strobes and `ser_out` low. The first clock after reset is released is a frame start with `frame_strobe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bit clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_sel | input | 1 | Interface strap: low selects serial operation, high idles the block |
| frame_ref_in | input | 1 | External frame reference, ignored in this mode |
| oh_vec_in | input | 56 | Overhead bit values, bit 8*s+b for block b of subframe s |
| pay_in | input | 1 | Serial payload from the upstream source |
| ser_out | output | 1 | Merged output bitstream, one clock behind the slot |
| frame_strobe | output | 1 | One-clock pulse in the frame-start slot |
| oh_ind | output | 1 | One-clock pulse in the clock before each overhead slot |

## Verification
The frame-start clock does three jobs at once. It samples the overhead vector, it emits the X bit taken straight from that fresh sample, and it follows the frame's final `oh_ind` pulse. The bench drives one overhead vector only in that single frame-start clock and a different vector in every other clock. The expected output is then correct only if the first bit and the whole following frame come from the one-clock sample. The bench also releases `rst` and `nib_sel` in the middle of a frame, so that a restart falls where a payload slot would have been. A behavioural slot model then judges whether the strobe, the X bit and the payload order restart together.

// File: rtl/ds3m_pkg.sv
`timescale 1ns/1ps
package ds3m_pkg;

  // total bits in one frame
  function automatic int frame_bits(int block_len, int blocks, int subs);
    return block_len * blocks * subs;
  endfunction

  // overhead vector index of block blk in subframe sub
  function automatic int oh_index(int sub, int blk, int blocks);
    return sub * blocks + blk;
  endfunction

  // width helper that never returns zero
  function automatic int cnt_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ds3m_slot_ctr.sv
`timescale 1ns/1ps
module ds3m_slot_ctr #(
  parameter int BLOCK_LEN = 85,
  parameter int BLOCKS    = 8,
  parameter int SUBS      = 7,
  localparam int PW = ds3m_pkg::cnt_width(BLOCK_LEN),
  localparam int BW = ds3m_pkg::cnt_width(BLOCKS),
  localparam int SW = ds3m_pkg::cnt_width(SUBS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  output logic [PW-1:0] pos,
  output logic [BW-1:0] blk,
  output logic [SW-1:0] sub,
  output logic          oh_slot,
  output logic          pre_oh,
  output logic          frame_start
);

  logic pos_last, blk_last, sub_last;

  assign pos_last = (pos == PW'(BLOCK_LEN - 1));
  assign blk_last = (blk == BW'(BLOCKS - 1));
  assign sub_last = (sub == SW'(SUBS - 1));

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pos <= '0;
      blk <= '0;
      sub <= '0;
    end else if (!pos_last) begin
      pos <= pos + 1'b1;
    end else begin
      pos <= '0;
      if (!blk_last) begin
        blk <= blk + 1'b1;
      end else begin
        blk <= '0;
        sub <= sub_last ? '0 : sub + 1'b1;
      end
    end
  end

  assign oh_slot     = (pos == '0);
  assign pre_oh      = pos_last;
  assign frame_start = oh_slot && (blk == '0) && (sub == '0);

endmodule

// File: rtl/ds3m_oh_store.sv
`timescale 1ns/1ps
module ds3m_oh_store #(
  parameter int BLOCKS = 8,
  parameter int SUBS   = 7,
  localparam int OH_W = BLOCKS * SUBS,
  localparam int BW   = ds3m_pkg::cnt_width(BLOCKS),
  localparam int SW   = ds3m_pkg::cnt_width(SUBS),
  localparam int IW   = ds3m_pkg::cnt_width(OH_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [OH_W-1:0] oh_vec_in,
  input  logic [BW-1:0]   blk,
  input  logic [SW-1:0]   sub,
  output logic            oh_bit
);

  logic [OH_W-1:0] held;
  logic [IW-1:0]   sel;

  always_comb sel = IW'(ds3m_pkg::oh_index(int'(sub), int'(blk), BLOCKS));

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (capture) held <= oh_vec_in;
  end

  // the capture clock uses the fresh vector directly
  always_comb oh_bit = capture ? oh_vec_in[sel] : held[sel];

endmodule

// File: rtl/ds3m_bit_mux.sv
`timescale 1ns/1ps
module ds3m_bit_mux (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic oh_slot,
  input  logic oh_bit,
  input  logic pay_in,
  output logic ser_out
);

  always_ff @(posedge clk) begin
    if (rst || idle) ser_out <= 1'b0;
    else ser_out <= oh_slot ? oh_bit : pay_in;
  end

endmodule

// File: rtl/ds3_tx_frame_master.sv
`timescale 1ns/1ps
module ds3_tx_frame_master #(
  parameter int BLOCK_LEN = 85,
  parameter int BLOCKS    = 8,
  parameter int SUBS      = 7,
  localparam int OH_W       = BLOCKS * SUBS,
  localparam int FRAME_BITS = ds3m_pkg::frame_bits(BLOCK_LEN, BLOCKS, SUBS),
  localparam int PW = ds3m_pkg::cnt_width(BLOCK_LEN),
  localparam int BW = ds3m_pkg::cnt_width(BLOCKS),
  localparam int SW = ds3m_pkg::cnt_width(SUBS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nib_sel,
  input  logic            frame_ref_in,
  input  logic [OH_W-1:0] oh_vec_in,
  input  logic            pay_in,
  output logic            ser_out,
  output logic            frame_strobe,
  output logic            oh_ind
);

  logic [PW-1:0] pos_w;
  logic [BW-1:0] blk_w;
  logic [SW-1:0] sub_w;
  logic oh_slot_w, pre_oh_w, frame_start_w, oh_bit_w, active_w, capture_w;
  logic unused_frame_ref;
  logic [PW-1:0] unused_pos;

  // the reference is not used when this block is the frame master
  assign unused_frame_ref = frame_ref_in;
  assign unused_pos       = pos_w;

  assign active_w  = !rst && !nib_sel;
  assign capture_w = frame_start_w && active_w;

  ds3m_slot_ctr #(.BLOCK_LEN(BLOCK_LEN), .BLOCKS(BLOCKS), .SUBS(SUBS)) u_ctr (
    .clk(clk), .rst(rst), .hold(nib_sel),
    .pos(pos_w), .blk(blk_w), .sub(sub_w),
    .oh_slot(oh_slot_w), .pre_oh(pre_oh_w), .frame_start(frame_start_w)
  );

  ds3m_oh_store #(.BLOCKS(BLOCKS), .SUBS(SUBS)) u_oh (
    .clk(clk), .rst(rst), .capture(capture_w), .oh_vec_in(oh_vec_in),
    .blk(blk_w), .sub(sub_w), .oh_bit(oh_bit_w)
  );

  ds3m_bit_mux u_mux (
    .clk(clk), .rst(rst), .idle(nib_sel), .oh_slot(oh_slot_w),
    .oh_bit(oh_bit_w), .pay_in(pay_in), .ser_out(ser_out)
  );

  assign frame_strobe = frame_start_w && active_w;
  assign oh_ind       = pre_oh_w && active_w;

endmodule

// File: rtl/ds3m_chk.sv
`timescale 1ns/1ps
module ds3m_chk #(
  parameter int FRAME_LEN = 4760
) (
  input logic clk,
  input logic rst,
  input logic nib_sel,
  input logic pay_in,
  input logic ser_out,
  input logic frame_strobe,
  input logic oh_ind,
  input logic oh_slot
);

  int   gap;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst || nib_sel) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (frame_strobe) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  // R1
  fs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> !frame_strobe);

  // R1
  fs_spacing_chk: assert property (@(posedge clk) disable iff (rst || nib_sel)
    (frame_strobe && seen) |-> (gap == FRAME_LEN - 1));

  // R1
  fs_due_chk: assert property (@(posedge clk) disable iff (rst || nib_sel)
    (seen && gap == FRAME_LEN - 1) |-> frame_strobe);

  // R2
  oh_lead_chk: assert property (@(posedge clk) disable iff (rst || nib_sel)
    oh_ind |=> oh_slot);

  // R2
  oh_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    oh_ind |=> !oh_ind);

  // R3
  pay_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!oh_slot && !nib_sel) |=> (ser_out == $past(pay_in)));

  // R6
  idle_strobe_chk: assert property (@(posedge clk)
    nib_sel |-> (!frame_strobe && !oh_ind));

  // R6
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    nib_sel |=> !ser_out);

  // R7
  rst_restart_chk: assert property (@(posedge clk)
    ($past(rst) && !rst && !nib_sel) |-> frame_strobe);

endmodule

bind ds3_tx_frame_master ds3m_chk #(.FRAME_LEN(FRAME_BITS)) u_chk (
  .clk(clk), .rst(rst), .nib_sel(nib_sel), .pay_in(pay_in),
  .ser_out(ser_out), .frame_strobe(frame_strobe), .oh_ind(oh_ind),
  .oh_slot(oh_slot_w)
);

// File: tb/test_ds3_tx_frame_master.sv
`timescale 1ns/1ps
module test_ds3_tx_frame_master;
  localparam int BL = 85, NB = 8, OHW = 56, SUBL = 680, FL = 4760;
  localparam logic [OHW-1:0] VA = 56'hA53C960F1E7D42;
  localparam logic [OHW-1:0] VB = 56'h5AC369F0E182BD;
  localparam logic [OHW-1:0] VC = 56'hFFFF0000FFFF00;

  logic clk = 1'b0, rst = 1'b1, nib_sel = 1'b0, frame_ref_in = 1'b0, pay_in = 1'b0;
  logic [OHW-1:0] oh_vec_in = '0;
  logic ser_out, frame_strobe, oh_ind;

  int vectors = 0, miscompares = 0;
  int m_slot = 0, p_idx = 0, frame_pay = 0;
  logic [OHW-1:0] m_held = '0;
  logic exp_ser = 1'b0;
  string exp_tag = "R7";
  string phase = "R7";
  bit done = 1'b0;

  ds3_tx_frame_master i_ds3_tx_frame_master (
    .clk(clk), .rst(rst), .nib_sel(nib_sel), .frame_ref_in(frame_ref_in),
    .oh_vec_in(oh_vec_in), .pay_in(pay_in), .ser_out(ser_out),
    .frame_strobe(frame_strobe), .oh_ind(oh_ind)
  );

  always #5ns clk = ~clk;

  // payload bit k of the source stream
  function automatic logic pbit(int k);
    logic [31:0] h;
    h = 32'(k) * 32'h9E3779B1;
    return h[17] ^ h[29] ^ h[3];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s phase=%s slot=%0d act=%b exp=%b", tag, phase, m_slot, act, exp);
    end
  endtask

  task automatic step(bit r, bit nib, logic [OHW-1:0] vec, bit rand_ref);
    bit idle;
    int j;
    logic nxt;
    @(negedge clk);
    rst = r;
    nib_sel = nib;
    oh_vec_in = vec;
    frame_ref_in = rand_ref ? 1'($urandom_range(0, 1)) : 1'b0;
    pay_in = pbit(p_idx);
    #1;
    idle = r || nib;
    chk("R1", frame_strobe, !idle && m_slot == 0);
    chk("R2", oh_ind, !idle && (m_slot % BL) == BL - 1);
    chk(exp_tag, ser_out, exp_ser);
    if (idle) begin
      nxt = 1'b0;
      exp_tag = r ? "R7" : "R6";
    end else if (m_slot % BL == 0) begin
      j = (m_slot / SUBL) * NB + (m_slot % SUBL) / BL;
      nxt = (m_slot == 0) ? vec[j] : m_held[j];
      exp_tag = "R4";
    end else begin
      nxt = pay_in;
      exp_tag = "R3";
    end
    @(posedge clk);
    exp_ser = nxt;
    if (idle) begin
      m_slot = 0;
    end else begin
      if (m_slot == 0) begin
        m_held = vec;
        frame_pay = 0;
      end
      if (m_slot % BL != 0) begin
        p_idx++;
        frame_pay++;
      end
      if (m_slot == FL - 1) begin
        vectors++;
        if (frame_pay != 4704) begin
          miscompares++;
          $display("FAIL R3 payload count act=%0d exp=4704", frame_pay);
        end
      end
      m_slot = (m_slot + 1) % FL;
    end
  endtask

  initial begin
    // R7: reset state
    for (int k = 0; k < 3; k++) step(1, 0, VA, 0);
    phase = "R1";
    for (int k = 0; k < FL; k++) step(0, 0, VA, 0);
    // R4: mid-frame vector change must be ignored
    phase = "R4";
    for (int k = 0; k < FL; k++) step(0, 0, (k < 200) ? VA : VB, 0);
    // R4: vector present only in the frame-start clock
    for (int k = 0; k < FL; k++) step(0, 0, (k == 0) ? VC : VA, 0);
    // R5: reference toggling has no effect
    phase = "R5";
    for (int k = 0; k < 2 * FL; k++) step(0, 0, VA, 1);
    // R6: strap high mid-frame, then restart
    phase = "R6";
    for (int k = 0; k < 1000; k++) step(0, 0, VB, 0);
    for (int k = 0; k < 40; k++) step(0, 1, VB, 1);
    for (int k = 0; k < FL + 10; k++) step(0, 0, VA, 0);
    // R7: reset mid-frame, then restart
    phase = "R7";
    for (int k = 0; k < 3; k++) step(1, 0, VA, 0);
    for (int k = 0; k < FL + 5; k++) step(0, 0, VC, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_900_000ns;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule